// File: doc/BRIEF.md
# Return-Address Stack Register

This block is a bounded last-in-first-out store of return addresses. An in-order core presents it as an ordinary general register. When an instruction names that register as a source, the top entry is removed. When an instruction names it as the destination, a new entry is added. One instruction may do both.

The block reports how full it is with a three-valued level: empty, partially filled or full. It raises an underflow when it must remove an entry and none is present. It raises an overflow when it must add an entry and no room is left. The core decodes instructions and drives one request per instruction. That request is two source-read enables, a write enable and write data. In return the core gets the top value and the error indications. What the core does about an error is outside this block.

Top module: `ret_stack_reg`

## Requirements
- R1: The stack holds up to DEPTH entries (default 8). Values come back in the reverse of the order they were written.
- R2: `rd_data` shows the current top entry combinationally, in the same cycle as the removal. It reads as zero while the stack is empty.
- R3: A request with `src_a_rd`, `src_b_rd` or both set removes exactly one entry. Both source operands take the same `rd_data` value.
- R4: A request that removes and adds in the same cycle overwrites the top entry in place and leaves the depth unchanged. This raises no overflow, even when the stack is full.
- R5: `fill_level` is registered and changes at the clock edge that completes a request. Its encoding is 0 for empty, 1 for partially filled (1 to DEPTH-1 entries) and 2 for full (DEPTH entries).
- R6: `underflow` is high in the cycle of any request that removes while the stack is empty. This includes a request that also adds.
- R7: `overflow` is high in the cycle of a request that adds without removing while the stack is full. `underflow` and `overflow` are never high together.
- R8: A request that raises `underflow` or `overflow` leaves both the depth and the stored entries unchanged.
- R9: `err_sticky` goes high at the edge after any error and stays high until reset. A synchronous `rst` empties the stack and clears `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_rd | input | 1 | First source operand names the stack register |
| src_b_rd | input | 1 | Second source operand names the stack register |
| dst_wr | input | 1 | Destination names the stack register |
| wr_data | input | WIDTH | Value to add |
| rd_data | output | WIDTH | Current top entry, zero when empty |
| fill_level | output | 2 | 0 empty, 1 partially filled, 2 full |
| underflow | output | 1 | Removal requested on an empty stack |
| overflow | output | 1 | Addition without removal requested on a full stack |
| err_sticky | output | 1 | Some error has occurred since reset |

## Verification
If the depth counter is wrong, it shows on `rd_data` at the next removal. It also shows on `fill_level` one edge after the request that caused it. A corrupted storage entry stays hidden until removals bring it back to the top. For that reason, every stimulus run later drains the stack completely and compares each returned value. If an error decision is wrong, it shows on `underflow` or `overflow` in the same cycle, and a wrong update after an error shows on the following removals. The bench keeps a queue of expected entries and compares every output on every cycle, so a divergence is caught at the first cycle that exposes it.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    LVL_EMPTY = 2'd0,
    LVL_PART  = 2'd1,
    LVL_FULL  = 2'd2
  } fill_lvl_e;
endpackage

// File: rtl/ret_stack_mem.sv
// Entry storage: one synchronous write port, one asynchronous read port.
module ret_stack_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ret_stack_ctrl.sv
// Depth tracking, error decisions, fill level and sticky error.
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_a,
  input  logic             pop_b,
  input  logic             push,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_waddr,
  output logic [PTR_W-1:0] mem_raddr,
  output logic             is_empty,
  output logic             uflow,
  output logic             oflow,
  output fill_lvl_e        level,
  output logic             err_sticky
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] top_idx;
  fill_lvl_e        level_q;
  logic             err_q;
  logic             pop, is_full, any_err;

  assign pop      = pop_a | pop_b;
  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CNT_MAX);
  assign top_idx  = PTR_W'(cnt_q - CNT_ONE);

  assign uflow   = pop & is_empty;
  assign oflow   = push & ~pop & is_full;
  assign any_err = uflow | oflow;

  assign mem_raddr = top_idx;

  always_comb begin
    cnt_d     = cnt_q;
    mem_we    = 1'b0;
    mem_waddr = PTR_W'(cnt_q);
    if (!any_err) begin
      if (pop && push) begin
        mem_we    = 1'b1;
        mem_waddr = top_idx;
      end else if (push) begin
        mem_we = 1'b1;
        cnt_d  = cnt_q + CNT_ONE;
      end else if (pop) begin
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  function automatic fill_lvl_e lvl_of(input logic [CNT_W-1:0] c);
    if (c == '0)          return LVL_EMPTY;
    else if (c == CNT_MAX) return LVL_FULL;
    else                  return LVL_PART;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= LVL_EMPTY;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= lvl_of(cnt_d);
      err_q   <= err_q | any_err;
    end
  end

  assign level      = level_q;
  assign err_sticky = err_q;

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

  // R5
  level_full_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q == LVL_FULL) == (cnt_q == CNT_MAX));

  // R4
  replace_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && push && !is_empty) |=> $stable(cnt_q));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (uflow || oflow) |=> $stable(cnt_q));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R7
  no_dual_err_chk: assert property (@(posedge clk) disable iff (rst)
    !(uflow && oflow));
endmodule

// File: rtl/ret_stack_reg.sv
module ret_stack_reg
  import ret_stack_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_a_rd,
  input  logic             src_b_rd,
  input  logic             dst_wr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic [1:0]       fill_level,
  output logic             underflow,
  output logic             overflow,
  output logic             err_sticky
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             mem_we, empty;
  logic [PTR_W-1:0] mem_waddr, mem_raddr;
  logic [WIDTH-1:0] mem_rdata;
  fill_lvl_e        level;

  ret_stack_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pop_a      (src_a_rd),
    .pop_b      (src_b_rd),
    .push       (dst_wr),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_raddr  (mem_raddr),
    .is_empty   (empty),
    .uflow      (underflow),
    .oflow      (overflow),
    .level      (level),
    .err_sticky (err_sticky)
  );

  ret_stack_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  assign rd_data    = empty ? '0 : mem_rdata;
  assign fill_level = level;

  // R2
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_level == 2'd0) |-> (rd_data == '0));
endmodule

// File: tb/ret_stack_reg_tb.sv
module ret_stack_reg_tb;
  localparam int WIDTH = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             src_a_rd = 1'b0, src_b_rd = 1'b0, dst_wr = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic [1:0]       fill_level;
  logic             underflow, overflow, err_sticky;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] q[$];
  bit sticky_m = 0;

  always #4 clk = ~clk;

  ret_stack_reg #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .src_a_rd(src_a_rd), .src_b_rd(src_b_rd),
    .dst_wr(dst_wr), .wr_data(wr_data), .rd_data(rd_data),
    .fill_level(fill_level), .underflow(underflow), .overflow(overflow),
    .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_lvl();
    if (q.size() == 0) return 0;
    if (q.size() == DEPTH) return 2;
    return 1;
  endfunction

  task automatic check_state(input string tag);
    chk(tag, "fill_level", fill_level, exp_lvl());
    chk("R9", "err_sticky", err_sticky, sticky_m);
  endtask

  task automatic step(input bit a, input bit b, input bit w, input logic [WIDTH-1:0] d, input string tag);
    bit pop, uf, of;
    logic [WIDTH-1:0] top;
    @(negedge clk);
    src_a_rd = a; src_b_rd = b; dst_wr = w; wr_data = d;
    #1;
    pop = a | b;
    top = (q.size() == 0) ? '0 : q[$];
    uf  = pop && (q.size() == 0);
    of  = w && !pop && (q.size() == DEPTH);
    chk((q.size() == 0) ? "R2" : tag, "rd_data", rd_data, top);
    chk("R6", "underflow", underflow, uf);
    chk("R7", "overflow", overflow, of);
    if (!uf && !of) begin
      if (pop && w) q[q.size()-1] = d;
      else if (w) q.push_back(d);
      else if (pop) void'(q.pop_back());
    end
    sticky_m = sticky_m | uf | of;
    @(posedge clk); #1;
    check_state(tag);
    src_a_rd = 0; src_b_rd = 0; dst_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    q.delete(); sticky_m = 0;
    rst = 1'b0;
    check_state("R9");
    chk("R9", "rd_data after reset", rd_data, 0);
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) step(1, 0, 0, '0, tag);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    do_reset();
    // R1: fill to capacity with distinct values
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 32'hA000_0000 + i, "R1");
    // R7: add on full without removal
    step(0, 0, 1, 32'hDEAD_BEEF, "R7");
    // R4: replace top while full, no overflow
    step(1, 0, 1, 32'h1234_5678, "R4");
    // R3: both sources name the register, one entry leaves
    step(1, 1, 0, '0, "R3");
    step(0, 1, 0, '0, "R3");
    // R8 and R1: remaining contents come back in reverse order, untouched by the overflow
    drain("R8");
    // R6: remove on empty, also while adding
    step(1, 0, 0, '0, "R6");
    step(0, 1, 1, 32'h5555_AAAA, "R8");
    step(0, 0, 1, 32'hCAFE_0001, "R8");
    step(1, 1, 1, 32'hCAFE_0002, "R4");
    drain("R2");
    // R9: reset mid-run with content
    step(0, 0, 1, 32'h7777_0000, "R9");
    step(0, 0, 1, 32'h7777_0001, "R9");
    do_reset();
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit ra, rb, w;
      ra = ($urandom % 3) == 0;
      rb = ($urandom % 5) == 0;
      w  = ($urandom % 2) == 0;
      step(ra, rb, w, $urandom, "R1");
      if (n % 150 == 149) begin
        drain("R8");
        do_reset();
      end
    end
    drain("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule